// File: doc/BRIEF.md
# Video Gain and Black-Level Loop Controller

This block holds the digital half of the two control loops in a two-channel (luma and chroma) 8-bit video digitiser. Each clock it may accept one sample pair: the luma and chroma ADC codes, each with its own underflow and overflow flag. Alongside the samples it watches two window pulses and an active-low peak-white enable. The sync window is gate A and the back-porch window is gate B. From these inputs it produces three charge-pump commands. The first steers the luma gain capacitor. The other two steer the luma and chroma clamp capacitors.

Each command is a direction (idle, up, down) and a magnitude class (small, clamp, strong). The analog side maps the classes to 8, 54 and 540 units. The gain loop pulls the sync tip to just above code 0, which leaves the sync amplitude about 64 codes below black. Peak white is limited with a strong discharge. The clamps hold luma black at code 64 and chroma at code 128.

After reset a fast-precharge phase runs for a parameterised number of back-porch windows. During this phase every non-idle command is raised to the strong class, so the loops settle quickly. The block also flags, and latches, any cycle in which both gates are high.

Samples enter on a valid/ready interface. `smp_ready` is low while reset is asserted and stays high from the first clock edge after it. The block never applies back-pressure, because a video sample cannot be held back. A sample counts as accepted when `smp_valid` and `smp_ready` are both high. The command side has no ready: `cmd_valid` marks the cycle that carries the result of an accepted sample.

Top module: `vid_loop_ctrl`

## Requirements
- R1: While reset is asserted, `smp_ready`, `cmd_valid` and `overlap_err` are 0, all directions are idle, and `precharge_active` is 1 when PRE_LINES > 0. `smp_ready` rises at the first clock edge after reset is released.
- R2: An accepted sample gives `cmd_valid`=1 with its commands on the clock edge that accepts it. A cycle with no accepted sample gives `cmd_valid`=0 and all three directions idle on the next edge.
- R3: With gate A high and no peak-white case, an underflowing luma code gives gain up, small. Any other luma code gives gain down, small. This includes code 255 without the overflow flag, and an overflow while peak white is disabled.
- R4: With `pw_en_n`=0 and the luma overflow flag set, the gain command is down, strong, whether gate A is high or low.
- R5: With gate A low and no peak-white case, the gain command is idle.
- R6: With gate B low, both clamp commands are idle.
- R7: With gate B high, the luma clamp compares against 64. A code below 64, or an underflow, gives up. A code above 64, or an overflow, gives down. Exactly 64 gives idle. The magnitude class is clamp.
- R8: With gate B high, the chroma clamp compares against 128 with the same rules as R7: below or underflow gives up, above or overflow gives down, exactly 128 gives idle.
- R9: `precharge_active` is 1 from reset until PRE_LINES falling edges of gate B have been seen, and it never rises again. While it is 1, every non-idle command on an accepted sample uses the strong class and keeps its direction.
- R10: A clock edge with both gates high sets `overlap_err`, which stays set until reset. An accepted sample in that cycle yields all three commands idle.
- R11: Direction encoding is 00 idle, 01 up, 10 down. Magnitude encoding is 00 small, 01 clamp, 10 strong. An idle command carries magnitude 00. If both flags of a channel are set, the underflow flag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample pair present |
| smp_ready | output | 1 | Block can take a sample (high after reset) |
| y_code | input | DW | Luma ADC code |
| y_under | input | 1 | Luma code below range |
| y_over | input | 1 | Luma code above range |
| c_code | input | DW | Chroma ADC code |
| c_under | input | 1 | Chroma code below range |
| c_over | input | 1 | Chroma code above range |
| gate_a | input | 1 | Sync-period window |
| gate_b | input | 1 | Back-porch window |
| pw_en_n | input | 1 | Peak-white limiting enable, active low |
| cmd_valid | output | 1 | Commands carry an accepted sample's result |
| gain_dir | output | 2 | Luma gain pump direction |
| gain_mag | output | 2 | Luma gain pump magnitude class |
| yclp_dir | output | 2 | Luma clamp pump direction |
| yclp_mag | output | 2 | Luma clamp pump magnitude class |
| cclp_dir | output | 2 | Chroma clamp pump direction |
| cclp_mag | output | 2 | Chroma clamp pump magnitude class |
| precharge_active | output | 1 | Fast-precharge phase running |
| overlap_err | output | 1 | Sticky gate overlap error |

## Verification
The bench builds the block with PRE_LINES=2 and keeps the default 8-bit codes and the targets of 64 and 128. With this setting, the end of precharge arrives after two short back-porch windows. Commands from both the strong phase and the normal phase can then be compared in one short run. Keeping the default width puts the exact targets, code 255 without a flag, and the flag cases directly on the input codes. Line-shaped random gating with random valid gaps exercises acceptance holes and peak-white toggling against the behavioural model.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } dir_e;

  typedef enum logic [1:0] {
    MAG_SMALL  = 2'b00,
    MAG_CLAMP  = 2'b01,
    MAG_STRONG = 2'b10
  } mag_e;

  typedef struct packed {
    dir_e dir;
    mag_e mag;
  } pump_cmd_t;

  localparam pump_cmd_t CMD_IDLE = '{dir: DIR_IDLE, mag: MAG_SMALL};

  // raise an active command to the strong class during precharge
  function automatic pump_cmd_t boost(input pump_cmd_t c, input logic pre);
    pump_cmd_t r;
    r = c;
    if (pre && c.dir != DIR_IDLE) r.mag = MAG_STRONG;
    return r;
  endfunction

endpackage

// File: rtl/vlc_gain_cmp.sv
module vlc_gain_cmp
  import vlc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] code,
  input  logic          under,
  input  logic          over,
  input  logic          gate_a,
  input  logic          pw_en_n,
  input  logic          pre,
  output pump_cmd_t     cmd
);

  logic      peak_hit;
  pump_cmd_t raw;

  // peak-white limiting needs a true overflow; underflow wins on conflict
  assign peak_hit = !pw_en_n && over && !under;

  always_comb begin
    raw = CMD_IDLE;
    if (peak_hit) begin
      raw = '{dir: DIR_DN, mag: MAG_STRONG};
    end else if (gate_a) begin
      // sync tip reference: below range -> raise gain, else lower it
      if (under) raw = '{dir: DIR_UP, mag: MAG_SMALL};
      else       raw = '{dir: DIR_DN, mag: MAG_SMALL};
    end
    cmd = boost(raw, pre);
  end

  logic unused_code;
  assign unused_code = ^code;

endmodule

// File: rtl/vlc_clamp_cmp.sv
module vlc_clamp_cmp
  import vlc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int TARGET = 64
) (
  input  logic [DW-1:0] code,
  input  logic          under,
  input  logic          over,
  input  logic          gate_b,
  input  logic          pre,
  output pump_cmd_t     cmd
);

  localparam logic [DW-1:0] TGT = DW'(TARGET);

  logic      below, above;
  pump_cmd_t raw;

  assign below = under || (!over && code < TGT);
  assign above = !under && (over || code > TGT);

  always_comb begin
    raw = CMD_IDLE;
    if (gate_b) begin
      if (below)      raw = '{dir: DIR_UP, mag: MAG_CLAMP};
      else if (above) raw = '{dir: DIR_DN, mag: MAG_CLAMP};
    end
    cmd = boost(raw, pre);
  end

endmodule

// File: rtl/vlc_precharge_seq.sv
module vlc_precharge_seq #(
  parameter int PRE_LINES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_b,
  output logic active
);

  localparam int CW = $clog2(PRE_LINES + 2);

  logic [CW-1:0] left_q;
  logic          prev_b_q;
  logic          win_end;

  assign win_end = prev_b_q && !gate_b;
  assign active  = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= CW'(PRE_LINES);
      prev_b_q <= 1'b0;
    end else begin
      prev_b_q <= gate_b;
      if (win_end && active) left_q <= left_q - 1'b1;
    end
  end

  // R9: once finished, precharge never comes back
  assert_pre_stays_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !active);

  // R9: the count only moves at the end of a back-porch window
  assert_pre_moves_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !win_end) |=> active);

endmodule

// File: rtl/vid_loop_ctrl.sv
module vid_loop_ctrl
  import vlc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int Y_TARGET  = 64,
  parameter int C_TARGET  = 128,
  parameter int PRE_LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] y_code,
  input  logic          y_under,
  input  logic          y_over,
  input  logic [DW-1:0] c_code,
  input  logic          c_under,
  input  logic          c_over,
  input  logic          gate_a,
  input  logic          gate_b,
  input  logic          pw_en_n,
  output logic          cmd_valid,
  output logic [1:0]    gain_dir,
  output logic [1:0]    gain_mag,
  output logic [1:0]    yclp_dir,
  output logic [1:0]    yclp_mag,
  output logic [1:0]    cclp_dir,
  output logic [1:0]    cclp_mag,
  output logic          precharge_active,
  output logic          overlap_err
);

  localparam int NCH = 2;

  logic          ready_q, valid_q, err_q;
  logic          accept, overlap, pre;
  pump_cmd_t     gain_c, gain_q;
  pump_cmd_t     clp_c [NCH];
  pump_cmd_t     clp_q [NCH];
  logic [DW-1:0] ch_code  [NCH];
  logic          ch_under [NCH];
  logic          ch_over  [NCH];

  assign accept  = smp_valid && ready_q;
  assign overlap = gate_a && gate_b;

  assign ch_code[0]  = y_code;
  assign ch_code[1]  = c_code;
  assign ch_under[0] = y_under;
  assign ch_under[1] = c_under;
  assign ch_over[0]  = y_over;
  assign ch_over[1]  = c_over;

  vlc_precharge_seq #(.PRE_LINES(PRE_LINES)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_b (gate_b),
    .active (pre)
  );

  vlc_gain_cmp #(.DW(DW)) u_gain (
    .code    (y_code),
    .under   (y_under),
    .over    (y_over),
    .gate_a  (gate_a),
    .pw_en_n (pw_en_n),
    .pre     (pre),
    .cmd     (gain_c)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_clamp
    vlc_clamp_cmp #(
      .DW     (DW),
      .TARGET ((ch == 0) ? Y_TARGET : C_TARGET)
    ) u_cmp (
      .code   (ch_code[ch]),
      .under  (ch_under[ch]),
      .over   (ch_over[ch]),
      .gate_b (gate_b),
      .pre    (pre),
      .cmd    (clp_c[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   clp_q[ch] <= CMD_IDLE;
      else if (accept && !overlap)  clp_q[ch] <= clp_c[ch];
      else                          clp_q[ch] <= CMD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      gain_q  <= CMD_IDLE;
    end else begin
      ready_q <= 1'b1;
      valid_q <= accept;
      err_q   <= err_q || overlap;
      gain_q  <= (accept && !overlap) ? gain_c : CMD_IDLE;
    end
  end

  assign smp_ready        = ready_q;
  assign cmd_valid        = valid_q;
  assign overlap_err      = err_q;
  assign precharge_active = pre;
  assign gain_dir         = gain_q.dir;
  assign gain_mag         = gain_q.mag;
  assign yclp_dir         = clp_q[0].dir;
  assign yclp_mag         = clp_q[0].mag;
  assign cclp_dir         = clp_q[1].dir;
  assign cclp_mag         = clp_q[1].mag;

  // R2: accepted sample shows up one edge later
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cmd_valid);

  // R2: no accepted sample -> nothing driven
  assert_no_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!cmd_valid && gain_dir == 2'b00 && yclp_dir == 2'b00 && cclp_dir == 2'b00));

  // R10: overlapping gates latch the error and silence the pumps
  assert_overlap_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && gate_a && gate_b) |=> (overlap_err && gain_dir == 2'b00 &&
                                       yclp_dir == 2'b00 && cclp_dir == 2'b00));

  // R10: error is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> overlap_err);

  // R6: clamps only act inside the back-porch window
  assert_clamp_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gate_b) |=> (yclp_dir == 2'b00 && cclp_dir == 2'b00));

  // R5: gain idle outside sync window unless peak white trips
  assert_gain_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gate_a && !(!pw_en_n && y_over && !y_under)) |=> gain_dir == 2'b00);

  // R4: peak-white limit is a strong discharge
  assert_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !overlap && !pw_en_n && y_over && !y_under) |=>
      (gain_dir == 2'b10 && gain_mag == 2'b10));

  // R7: an active clamp never uses the small class
  assert_clamp_mag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (yclp_dir != 2'b00) |-> (yclp_mag != 2'b00));

  // R11: only the three direction codes appear
  assert_dir_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_dir != 2'b11 && yclp_dir != 2'b11 && cclp_dir != 2'b11));

endmodule

// File: tb/vid_loop_ctrl_tb_top.sv
module vid_loop_ctrl_tb_top;

  localparam int PRE = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid, smp_ready;
  logic [7:0] y_code, c_code;
  logic       y_under, y_over, c_under, c_over;
  logic       gate_a, gate_b, pw_en_n;
  logic       cmd_valid, precharge_active, overlap_err;
  logic [1:0] gain_dir, gain_mag, yclp_dir, yclp_mag, cclp_dir, cclp_mag;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  bit    m_ready, m_prevb, m_err;
  int    m_left;
  bit    e_valid;
  int    e_gain, e_yclp, e_cclp;
  string t_gain, t_yclp, t_cclp;

  always #4 clk = ~clk;

  vid_loop_ctrl #(.PRE_LINES(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .y_code(y_code), .y_under(y_under), .y_over(y_over),
    .c_code(c_code), .c_under(c_under), .c_over(c_over),
    .gate_a(gate_a), .gate_b(gate_b), .pw_en_n(pw_en_n),
    .cmd_valid(cmd_valid), .gain_dir(gain_dir), .gain_mag(gain_mag),
    .yclp_dir(yclp_dir), .yclp_mag(yclp_mag), .cclp_dir(cclp_dir), .cclp_mag(cclp_mag),
    .precharge_active(precharge_active), .overlap_err(overlap_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // R11: units -> {dir, mag}; 8 small, 54 clamp, 540 strong
  function automatic int enc(input int u);
    int d, m, a;
    if (u == 0) return 0;
    d = (u > 0) ? 1 : 2;
    a = (u > 0) ? u : -u;
    m = (a == 8) ? 0 : (a == 54) ? 1 : 2;
    return d * 4 + m;
  endfunction

  task automatic tick(input bit v, input bit a, input bit b, input bit pwn,
                      input int yc, input bit yu, input bit yo,
                      input int cc, input bit cu, input bit co);
    bit acc, pre;
    int yv, cv, s;
    smp_valid = v; gate_a = a; gate_b = b; pw_en_n = pwn;
    y_code = 8'(yc); y_under = yu; y_over = yo;
    c_code = 8'(cc); c_under = cu; c_over = co;
    acc = v && m_ready;
    pre = (m_left > 0);
    yv = yu ? -1 : (yo ? 256 : yc);
    cv = cu ? -1 : (co ? 256 : cc);
    s  = pre ? 10 : 1;
    e_valid = acc;
    e_gain = 0; e_yclp = 0; e_cclp = 0;
    t_gain = "R2"; t_yclp = "R2"; t_cclp = "R2";
    if (acc && a && b) begin
      t_gain = "R10"; t_yclp = "R10"; t_cclp = "R10";
    end else if (acc) begin
      if (!pwn && yv > 255) begin e_gain = -540; t_gain = "R4"; end
      else if (a) begin
        e_gain = (yv < 0) ? 8 * s : -8 * s;
        e_gain = (e_gain == 80) ? 540 : (e_gain == -80) ? -540 : e_gain;
        t_gain = pre ? "R9" : "R3";
      end else t_gain = "R5";
      if (b) begin
        e_yclp = (yv < 64) ? 54 : (yv > 64) ? -54 : 0;
        e_cclp = (cv < 128) ? 54 : (cv > 128) ? -54 : 0;
        if (pre) begin e_yclp = e_yclp * 10; e_cclp = e_cclp * 10; end
        if (e_yclp == 540 || e_yclp == -540) ; // strong class
        t_yclp = pre ? "R9" : "R7"; t_cclp = pre ? "R9" : "R8";
      end else begin t_yclp = "R6"; t_cclp = "R6"; end
    end
    // state update at the edge
    if (a && b) m_err = 1;
    if (m_prevb && !b && m_left > 0) m_left--;
    m_prevb = b;
    m_ready = 1;
    @(negedge clk);
    chk("R2", "cmd_valid", int'(cmd_valid), int'(e_valid));
    chk(t_gain, "gain", int'({gain_dir, gain_mag}), enc(e_gain));
    chk(t_yclp, "yclp", int'({yclp_dir, yclp_mag}), enc(e_yclp == 540 || e_yclp == -540 ? e_yclp : e_yclp));
    chk(t_cclp, "cclp", int'({cclp_dir, cclp_mag}), enc(e_cclp));
    chk("R9", "precharge", int'(precharge_active), int'(m_left > 0));
    chk("R10", "overlap_err", int'(overlap_err), int'(m_err));
    chk("R1", "ready", int'(smp_ready), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    smp_valid = 0; gate_a = 0; gate_b = 0; pw_en_n = 1;
    y_code = 0; c_code = 0; y_under = 0; y_over = 0; c_under = 0; c_over = 0;
    m_ready = 0; m_prevb = 0; m_err = 0; m_left = PRE;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ready", int'(smp_ready), 0);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);
    chk("R1", "dirs", int'({gain_dir, yclp_dir, cclp_dir}), 0);
    chk("R1", "overlap_err", int'(overlap_err), 0);
    chk("R1", "precharge", int'(precharge_active), 1);
    rst_n = 1'b1;
    tick(1, 0, 0, 1, 100, 0, 0, 128, 0, 0); // not accepted: ready still low
    // R9 precharge: strong magnitudes
    tick(1, 1, 0, 1, 0, 1, 0, 128, 0, 0);
    tick(1, 1, 0, 1, 30, 0, 0, 128, 0, 0);
    tick(1, 0, 1, 1, 10, 0, 0, 200, 0, 0);
    tick(1, 0, 1, 1, 64, 0, 0, 128, 0, 0);
    tick(1, 0, 0, 1, 64, 0, 0, 128, 0, 0); // first window end
    tick(1, 0, 1, 1, 90, 0, 0, 5, 0, 0);
    tick(1, 0, 0, 1, 90, 0, 0, 5, 0, 0);   // second window end -> normal
    // R3 gate A corners
    tick(1, 1, 0, 1, 0, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 0, 1, 255, 0, 0, 0, 0, 0);
    tick(1, 1, 0, 1, 255, 0, 1, 0, 0, 0);
    // R4 peak white in and out of gate A, R5 idle
    tick(1, 0, 0, 0, 255, 0, 1, 0, 0, 0);
    tick(1, 1, 0, 0, 255, 0, 1, 0, 0, 0);
    tick(1, 0, 0, 1, 255, 0, 1, 0, 0, 0);
    tick(1, 0, 0, 0, 200, 0, 0, 0, 0, 0);
    // R7 / R8 targets
    tick(1, 0, 1, 1, 63, 0, 0, 127, 0, 0);
    tick(1, 0, 1, 1, 64, 0, 0, 128, 0, 0);
    tick(1, 0, 1, 1, 65, 0, 0, 129, 0, 0);
    tick(1, 0, 1, 1, 0, 1, 0, 0, 0, 1);
    tick(1, 0, 1, 1, 255, 0, 1, 0, 1, 0);
    tick(1, 0, 1, 0, 255, 0, 1, 50, 0, 0);
    tick(0, 0, 1, 1, 10, 0, 0, 10, 0, 0);  // R2 gap
    tick(1, 0, 0, 1, 10, 0, 0, 10, 0, 0);  // R6
    // random line-shaped traffic
    for (int i = 0; i < 600; i++) begin
      int p, sel;
      bit a, b, yu, yo;
      int yc, cc;
      p = i % 30;
      a = (p >= 3 && p <= 6);
      b = (p >= 10 && p <= 14);
      sel = int'($urandom % 8);
      yu = (sel == 0); yo = (sel == 1);
      yc = (sel == 2) ? 64 : (sel == 3) ? 255 : int'($urandom % 256);
      cc = (sel == 4) ? 128 : int'($urandom % 256);
      tick(($urandom % 5) != 0, a, b, ((i / 90) % 2) == 0, yc, yu, yo, cc,
           sel == 5, sel == 6);
    end
    // R10 overlap and stickiness
    tick(1, 1, 1, 0, 255, 0, 1, 10, 0, 0);
    tick(1, 0, 1, 1, 10, 0, 0, 10, 0, 0);
    tick(1, 1, 0, 1, 0, 1, 0, 10, 0, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule